// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a downstream port that supports hot-plug. Software commands the slot by writing the control word. It acknowledges events by writing ones into the status word. The slot side reports attention-button presses and device arrival or departure. A port-reset input returns the registers to their reset defaults.

Each cycle the block works out whether an enabled hot-plug event is pending. It signals software only when that answer changes. With MSI-X or MSI enabled, the signal is a one-cycle message pulse that carries a 5-bit vector. With neither enabled, it is a level INTx output.

All state is registered. Register writes, events and requests take effect on the clock edge, and their results are visible from the next cycle on. Reads are combinational from the registers.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Each cycle with `wr_ctl_i` high is one command. Writable control bits are 0 (button enable), 3 (presence-change enable), 4 (command-done enable), 5 (interrupt enable), 7:6 and 9:8 (indicators) and 11 (interlock control). These bits take `wr_data_i`, and the command-done status bit 4 reads 1 from the next cycle.
- R2: A control write with bit 11 set inverts interlock status (status bit 7). Control bit 11 always reads 0.
- R3: A status write (`wr_sts_i`) clears each of status bits 0 (button pressed), 3 (presence changed) and 4 (command done) where the data bit is 1. Data bits that are 0, and all other status bits, are left unchanged.
- R4: The pending condition is control bit 5 AND (nonzero status & control & 0x0019).
- R5: A notification is raised only in a cycle with a control write or a newly set event bit, and only if the pending condition then differs from the last evaluated value. Re-setting an event bit that is already set raises nothing.
- R6: Notification routing. With `msix_en_i` set, `msg_valid_o` pulses for one cycle with `msg_msix_o`=1. Otherwise, with `msi_en_i` set, it pulses with `msg_msix_o`=0. In both cases `msg_vector_o` equals `vector_i`. With neither set, `intx_o` takes the new condition.
- R7: When a status write or a port reset leaves no condition pending and neither message form is enabled, `intx_o` goes low.
- R8: `plug_op_i` selects the slot request: 0 = present at power-up (sets presence state bit 6, with no event), 1 = insertion (sets bit 6 and bit 3), 2 = removal (clears bit 6, sets bit 3), 3 = no effect.
- R9: An insertion or removal request while interlock status is 1 raises `plug_busy_o` in the same cycle and changes no state.
- R10: A port reset sets the control word to 0x03C0 (every enable cleared, both indicators set to off, code 2'b11). It clears status bits 0, 3, 4 and 7, keeps presence state, and raises no notification.
- R11: When an event sets a status bit in the same cycle that a status write clears it, the bit ends up set. A port reset overrides every other input in that cycle.
- R12: After `rst_n` the control word reads 0x03C0, the status word reads 0, and `intx_o` and `msg_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ctl_i | input | 1 | Write the slot control word |
| wr_sts_i | input | 1 | Write-one-to-clear the slot status word |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 1 | Read select: 0 control, 1 status |
| rd_data_o | output | 16 | Read data |
| button_i | input | 1 | Attention-button press pulse |
| plug_req_i | input | 1 | Slot request strobe |
| plug_op_i | input | 2 | Slot request kind |
| plug_busy_o | output | 1 | Request rejected because the interlock is engaged |
| port_reset_i | input | 1 | Port reset to slot register defaults |
| msix_en_i | input | 1 | MSI-X enabled |
| msi_en_i | input | 1 | MSI enabled |
| vector_i | input | VEC_W | Message vector |
| msg_valid_o | output | 1 | One-cycle message request |
| msg_msix_o | output | 1 | The message is MSI-X (1) or MSI (0) |
| msg_vector_o | output | VEC_W | Vector of the message |
| intx_o | output | 1 | INTx level |

## Verification
On every cycle the assertions check these properties:
- A command sets command-done status.
- An interlock-control write flips the interlock.
- A busy request leaves presence state alone.
- A port reset forces the control defaults.
- A write-one-to-clear clears the bit when no event sets it again.
- Messages appear only when the condition changes.
- INTx stays put while a message form is enabled, and drops after a re-evaluation that finds nothing pending.

Only the bench scenarios can show the rest. These are the exact register contents after mixed writes, events and requests in the same cycle, the routing choice between MSI-X, MSI and INTx, and the absence of a message when an event repeats.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int REG_W = 16;

  // control bit positions
  localparam int C_BTN_EN  = 0;
  localparam int C_PDC_EN  = 3;
  localparam int C_CC_EN   = 4;
  localparam int C_IRQ_EN  = 5;
  localparam int C_LOCK    = 11;
  // status bit positions
  localparam int S_BTN     = 0;
  localparam int S_PDC     = 3;
  localparam int S_CC      = 4;
  localparam int S_PRESENT = 6;
  localparam int S_LOCK    = 7;

  localparam logic [REG_W-1:0] CTL_WMASK = 16'h0BF9;
  localparam logic [REG_W-1:0] CTL_KEEP  = 16'h03F9;
  localparam logic [REG_W-1:0] EV_MASK   = 16'h0019;
  localparam logic [REG_W-1:0] CTL_RESET = 16'h03C0;
  localparam logic [REG_W-1:0] STS_RCLR  = 16'h0099;

  typedef enum logic [1:0] {
    PLUG_COLD   = 2'd0,
    PLUG_INSERT = 2'd1,
    PLUG_REMOVE = 2'd2,
    PLUG_NONE   = 2'd3
  } plug_op_e;

  function automatic logic pend_cond(input logic [REG_W-1:0] ctl,
                                     input logic [REG_W-1:0] sts);
    return ctl[C_IRQ_EN] && ((sts & ctl & EV_MASK) != '0);
  endfunction

  function automatic logic [REG_W-1:0] ctl_apply(input logic [REG_W-1:0] ctl,
                                                 input logic [REG_W-1:0] wd);
    return ((ctl & ~CTL_WMASK) | (wd & CTL_WMASK)) & CTL_KEEP;
  endfunction
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_sts,
  input  logic [REG_W-1:0] wr_data,
  input  logic             button,
  input  logic             plug_req,
  input  logic [1:0]       plug_op,
  input  logic             port_reset,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] sts_q,
  output logic             busy,
  output logic             notify,
  output logic             cond_nx
);
  logic [REG_W-1:0] ctl_d, sts_d;
  logic             hot_op, plug_ok;

  assign hot_op  = (plug_op == PLUG_INSERT) || (plug_op == PLUG_REMOVE);
  assign busy    = plug_req && hot_op && sts_q[S_LOCK];
  assign plug_ok = plug_req && !busy;

  always_comb begin
    ctl_d  = ctl_q;
    sts_d  = sts_q;
    notify = 1'b0;
    if (wr_sts) sts_d = sts_d & ~(wr_data & EV_MASK);
    if (wr_ctl) begin
      ctl_d = ctl_apply(ctl_q, wr_data);
      if (wr_data[C_LOCK]) sts_d[S_LOCK] = ~sts_d[S_LOCK];
      sts_d[S_CC] = 1'b1;
      notify = 1'b1;
    end
    if (button) begin
      notify = notify | !sts_q[S_BTN];
      sts_d[S_BTN] = 1'b1;
    end
    if (plug_ok) begin
      case (plug_op)
        PLUG_COLD:   sts_d[S_PRESENT] = 1'b1;
        PLUG_INSERT: begin
          sts_d[S_PRESENT] = 1'b1;
          sts_d[S_PDC] = 1'b1;
          notify = notify | !sts_q[S_PDC];
        end
        PLUG_REMOVE: begin
          sts_d[S_PRESENT] = 1'b0;
          sts_d[S_PDC] = 1'b1;
          notify = notify | !sts_q[S_PDC];
        end
        default: ;
      endcase
    end
    if (port_reset) begin
      ctl_d  = CTL_RESET;
      sts_d  = sts_d & ~STS_RCLR;
      notify = 1'b0;
    end
  end

  assign cond_nx = pend_cond(ctl_d, sts_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      sts_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      sts_q <= sts_d;
    end
  end

  // R1: a command marks command-done
  a_r1_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !port_reset) |=> sts_q[S_CC]);
  // R2: interlock control flips interlock status
  a_r2_lock_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wr_data[C_LOCK] && !port_reset) |=> (sts_q[S_LOCK] != $past(sts_q[S_LOCK])));
  // R3: a cleared button bit stays clear unless pressed again
  a_r3_w1c_btn: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wr_data[S_BTN] && !button) |=> !sts_q[S_BTN]);
  // R9: a busy request leaves presence untouched
  a_r9_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sts_q[S_PRESENT]));
  // R10: port reset defaults
  a_r10_reset_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    port_reset |=> (ctl_q == CTL_RESET) && !sts_q[S_LOCK]);
endmodule

// File: rtl/hp_irq_route.sv
module hp_irq_route #(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             notify,
  input  logic             reeval,
  input  logic             cond_nx,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] vector,
  output logic             msg_valid,
  output logic             msg_msix,
  output logic [VEC_W-1:0] msg_vector,
  output logic             intx
);
  logic notif_q, changed, any_msg;

  assign any_msg = msix_en || msi_en;
  assign changed = notify && (cond_nx != notif_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notif_q    <= 1'b0;
      msg_valid  <= 1'b0;
      msg_msix   <= 1'b0;
      msg_vector <= '0;
      intx       <= 1'b0;
    end else begin
      notif_q    <= cond_nx;
      msg_valid  <= changed && any_msg;
      msg_msix   <= msix_en;
      msg_vector <= vector;
      if (changed && !any_msg)                   intx <= cond_nx;
      else if (reeval && !any_msg && !cond_nx)   intx <= 1'b0;
    end
  end

  // R5: a message only follows a change of the condition
  a_r5_msg_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (notif_q != $past(notif_q)));
  // R6: with a message form enabled, INTx is left alone
  a_r6_intx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    any_msg |=> $stable(intx));
  // R7: re-evaluation with nothing pending drops INTx
  a_r7_intx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (reeval && !any_msg && !cond_nx) |=> !intx);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl_i,
  input  logic             wr_sts_i,
  input  logic [15:0]      wr_data_i,
  input  logic             rd_sel_i,
  output logic [15:0]      rd_data_o,
  input  logic             button_i,
  input  logic             plug_req_i,
  input  logic [1:0]       plug_op_i,
  output logic             plug_busy_o,
  input  logic             port_reset_i,
  input  logic             msix_en_i,
  input  logic             msi_en_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic             msg_valid_o,
  output logic             msg_msix_o,
  output logic [VEC_W-1:0] msg_vector_o,
  output logic             intx_o
);
  logic [REG_W-1:0] ctl_q, sts_q;
  logic             notify, cond_nx;

  hp_slot_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(wr_ctl_i), .wr_sts(wr_sts_i), .wr_data(wr_data_i),
    .button(button_i), .plug_req(plug_req_i), .plug_op(plug_op_i),
    .port_reset(port_reset_i),
    .ctl_q(ctl_q), .sts_q(sts_q), .busy(plug_busy_o),
    .notify(notify), .cond_nx(cond_nx)
  );

  hp_irq_route #(.VEC_W(VEC_W)) u_route (
    .clk(clk), .rst_n(rst_n),
    .notify(notify), .reeval(wr_sts_i || port_reset_i), .cond_nx(cond_nx),
    .msix_en(msix_en_i), .msi_en(msi_en_i), .vector(vector_i),
    .msg_valid(msg_valid_o), .msg_msix(msg_msix_o),
    .msg_vector(msg_vector_o), .intx(intx_o)
  );

  assign rd_data_o = rd_sel_i ? sts_q : ctl_q;
endmodule

// File: tb/tb_hp_slot_ctrl.sv
`timescale 1ns/100ps
module tb_hp_slot_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_ctl = 0, wr_sts = 0, rd_sel = 0, button = 0, plug_req = 0, port_reset = 0;
  logic msix_en = 0, msi_en = 0;
  logic [15:0] wr_data = '0, rd_data;
  logic [1:0] plug_op = '0;
  logic [4:0] vector = '0, msg_vector;
  logic plug_busy, msg_valid, msg_msix, intx;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [15:0] m_ctl, m_sts;
  logic m_notif, m_intx;

  always #2.5 clk = ~clk;

  hp_slot_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_ctl_i(wr_ctl), .wr_sts_i(wr_sts),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .button_i(button), .plug_req_i(plug_req), .plug_op_i(plug_op),
    .plug_busy_o(plug_busy), .port_reset_i(port_reset),
    .msix_en_i(msix_en), .msi_en_i(msi_en), .vector_i(vector),
    .msg_valid_o(msg_valid), .msg_msix_o(msg_msix),
    .msg_vector_o(msg_vector), .intx_o(intx)
  );

  function automatic logic model_cond(input logic [15:0] c, input logic [15:0] s);
    return c[5] & ((c[0] & s[0]) | (c[3] & s[3]) | (c[4] & s[4]));
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic wc, input logic ws, input logic [15:0] wd,
                      input logic btn, input logic pr, input logic [1:0] op, input logic prst);
    logic [15:0] c, s;
    logic bsy, ntf, cnd, anym, exp_msg, ni;
    @(negedge clk);
    wr_ctl = wc; wr_sts = ws; wr_data = wd; button = btn;
    plug_req = pr; plug_op = op; port_reset = prst;
    #1;
    bsy = pr && (op == 2'd1 || op == 2'd2) && m_sts[7];
    chk(tag, "busy", 32'(plug_busy), 32'(bsy));
    c = m_ctl; s = m_sts; ntf = 0;
    if (ws) begin
      if (wd[0]) s[0] = 0;
      if (wd[3]) s[3] = 0;
      if (wd[4]) s[4] = 0;
    end
    if (wc) begin
      c = {4'b0, wd[11:0]} & 16'h03F9;
      if (wd[11]) s[7] = ~s[7];
      s[4] = 1; ntf = 1;
    end
    if (btn) begin if (!m_sts[0]) ntf = 1; s[0] = 1; end
    if (pr && !bsy) begin
      if (op == 2'd0) s[6] = 1;
      if (op == 2'd1) begin s[6] = 1; s[3] = 1; if (!m_sts[3]) ntf = 1; end
      if (op == 2'd2) begin s[6] = 0; s[3] = 1; if (!m_sts[3]) ntf = 1; end
    end
    if (prst) begin
      c = 16'h03C0; s[0] = 0; s[3] = 0; s[4] = 0; s[7] = 0; ntf = 0;
    end
    cnd = model_cond(c, s);
    anym = msix_en | msi_en;
    exp_msg = ntf && (cnd != m_notif) && anym;
    ni = m_intx;
    if (ntf && (cnd != m_notif) && !anym) ni = cnd;
    else if ((ws || prst) && !anym && !cnd) ni = 0;
    @(posedge clk); #0.5;
    m_ctl = c; m_sts = s; m_notif = cnd; m_intx = ni;
    rd_sel = 0; #0.2;
    chk(tag, "ctl", 32'(rd_data), 32'(m_ctl));
    rd_sel = 1; #0.2;
    chk(tag, "sts", 32'(rd_data), 32'(m_sts));
    chk(tag, "intx", 32'(intx), 32'(m_intx));
    chk(tag, "msg_valid", 32'(msg_valid), 32'(exp_msg));
    if (exp_msg) begin
      chk(tag, "msg_vector", 32'(msg_vector), 32'(vector));
      chk(tag, "msg_msix", 32'(msg_msix), 32'(msix_en));
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 16'h0, 0, 0, 2'd0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_ctl = 16'h03C0; m_sts = '0; m_notif = 0; m_intx = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    #1 rd_sel = 0; #0.2;
    chk("R12", "reset ctl", 32'(rd_data), 32'h03C0);
    rd_sel = 1; #0.2;
    chk("R12", "reset sts", 32'(rd_data), 32'h0);
    chk("R12", "reset intx", 32'(intx), 32'h0);
    chk("R12", "reset msg", 32'(msg_valid), 32'h0);

    // R1 / R6: command with interrupt + command-done enable raises INTx
    step("R1", 1, 0, 16'h0039, 0, 0, 2'd0, 0);
    // R4: interrupt enable off -> no pending despite events
    step("R4", 1, 0, 16'h0019, 0, 0, 2'd0, 0);
    step("R4", 1, 0, 16'h0039, 0, 0, 2'd0, 0);
    // R2: interlock toggle, bit 11 reads 0
    step("R2", 1, 0, 16'h0839, 0, 0, 2'd0, 0);
    // R9: hot requests rejected while locked, cold accepted
    step("R9", 0, 0, 16'h0, 0, 1, 2'd1, 0);
    step("R9", 0, 0, 16'h0, 0, 1, 2'd2, 0);
    step("R8", 0, 0, 16'h0, 0, 1, 2'd0, 0);
    step("R2", 1, 0, 16'h0839, 0, 0, 2'd0, 0);
    // R3 / R7: clear command-done drops INTx
    step("R7", 0, 1, 16'h0010, 0, 0, 2'd0, 0);
    step("R3", 0, 1, 16'h00C0, 0, 0, 2'd0, 0);
    // R6: MSI-X message on button
    msix_en = 1; vector = 5'd19;
    step("R6", 0, 0, 16'h0, 1, 0, 2'd0, 0);
    // R5: repeat press raises nothing
    step("R5", 0, 0, 16'h0, 1, 0, 2'd0, 0);
    idle("R5");
    // R11: clear and press together keep the bit set
    step("R11", 0, 1, 16'h0001, 1, 0, 2'd0, 0);
    // R6: MSI path
    msix_en = 0; msi_en = 1; vector = 5'd31;
    step("R6", 0, 1, 16'h0019, 0, 0, 2'd0, 0);
    step("R8", 0, 0, 16'h0, 0, 1, 2'd2, 0);
    step("R8", 0, 0, 16'h0, 0, 1, 2'd1, 0);
    step("R8", 0, 0, 16'h0, 0, 1, 2'd3, 0);
    msi_en = 0;
    // R10: port reset wins over a simultaneous command
    step("R10", 1, 0, 16'h0839, 1, 0, 2'd0, 1);
    idle("R10");

    for (int i = 0; i < 600; i++) begin
      logic wc, ws, btn, pr, prst;
      logic [15:0] wd;
      if ($urandom_range(0, 19) == 0) msix_en = 1'($urandom);
      if ($urandom_range(0, 19) == 0) msi_en = 1'($urandom);
      vector = 5'($urandom);
      wc = ($urandom_range(0, 3) == 0);
      ws = ($urandom_range(0, 3) == 0);
      wd = 16'($urandom);
      if ($urandom_range(0, 2) != 0) wd[5] = 1'b1;
      btn = ($urandom_range(0, 5) == 0);
      pr = ($urandom_range(0, 5) == 0);
      prst = ($urandom_range(0, 39) == 0);
      step("R11", wc, ws, wd, btn, pr, 2'($urandom), prst);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule